// File: doc/BRIEF.md
# ECC DIMM Pair Resolver

When a memory error is reported against a chip-select that drives two DIMMs side by side, something has to decide which DIMM to blame. This block makes that decision in one clock. It takes the DIMM-present flags for the pair, the physical address and the lowest address bit known to be valid, the ECC mode, and a symbol that has already been decoded from the syndrome. It returns a two-bit code naming the lower DIMM, the upper DIMM, or both.

Each ECC mode needs a different rule. In 64/8 mode each 64-bit half carries its own check bits, so the address bit that picks the half also picks the DIMM. That only works if that address bit is known. In symbol mode a correctable error is placed by the bit position of the failing symbol. An uncorrectable error in symbol mode cannot be placed, so both DIMMs are reported.

If the inputs cannot yield an answer, one of three error flags is raised instead of a code:
- no DIMM is present,
- the address resolution is too coarse,
- the symbol decode is invalid.

The answer is registered. It appears with a valid strobe one cycle after the request.

Top module: `dimm_pair_resolver`

## Requirements
- R1: If a request has neither DIMM-present flag set, the result raises `err_nodimm` and `dimm_sel` is 2'b00.
- R2: If a request has exactly one DIMM-present flag set, the result is `dimm_sel` = 2'b01 (lower), whatever the mode, address or symbol.
- R3: In 64/8 mode (`ecc_mode`=0) with both DIMMs present and `valid_lsb` <= 3, address bit 3 = 1 gives 2'b10 (upper) and address bit 3 = 0 gives 2'b01 (lower).
- R4: In 64/8 mode with both DIMMs present and `valid_lsb` > 3, the result raises `err_insuff` with `dimm_sel` = 2'b00.
- R5: In symbol mode (`ecc_mode`=1) with both DIMMs present, a correctable error and a valid symbol, the result is 2'b01 in two cases: a data symbol (`sym_is_data`=1) with `sym_hibit` <= 63, or a check symbol with `sym_hibit` <= 7. Any other valid symbol gives 2'b10.
- R6: In symbol mode with both DIMMs present and `corr`=0, the result is 2'b11 (both), whatever `sym_ok` says.
- R7: In symbol mode with both DIMMs present, `corr`=1 and `sym_ok`=0, the result raises `err_synd` with `dimm_sel` = 2'b00.
- R8: `out_valid` is high exactly one cycle after each cycle with `in_valid` high. While `out_valid` is low, all result outputs are zero. After reset, all outputs are zero.
- R9: While `out_valid` is high, exactly one of the following holds: a nonzero `dimm_sel`, or one of the three error flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| lo_present | input | 1 | Lower DIMM of the pair is populated |
| hi_present | input | 1 | Upper DIMM of the pair is populated |
| phys_addr | input | ADDR_W | Physical address of the error |
| valid_lsb | input | LSB_W | Lowest address bit that is valid |
| ecc_mode | input | 1 | 0 = 64/8 per-half ECC, 1 = symbol ECC |
| corr | input | 1 | Error is correctable |
| sym_ok | input | 1 | Decoded symbol information is valid |
| sym_is_data | input | 1 | 1 = data symbol, 0 = check symbol |
| sym_hibit | input | SYM_W | Highest bit position covered by the symbol |
| out_valid | output | 1 | Result strobe |
| dimm_sel | output | 2 | bit0 = lower DIMM, bit1 = upper DIMM |
| err_nodimm | output | 1 | No DIMM present |
| err_insuff | output | 1 | Address resolution too coarse |
| err_synd | output | 1 | Symbol decode invalid |

## Verification
The bench probes each threshold on both sides:
- `valid_lsb` at 3 and at 4. A design with an off-by-one compare would place an error it cannot resolve, or refuse one it can.
- Data symbol high bit at 63 and 64, and check symbol high bit at 7 and 8. Getting either limit wrong sends the error to the wrong DIMM.
- An uncorrectable request with `sym_ok` low. This catches a design that tests symbol validity before correctability: it would raise `err_synd` where 2'b11 is due.
- Each single-DIMM case with an upper-half address. A design that follows the address there would answer 2'b10 where 2'b01 is required.
- An idle cycle after a request. A design that holds its last result would leave `dimm_sel` nonzero with `out_valid` low.

// File: rtl/dimm_pair_resolver.sv
module dimm_pair_resolver #(
  parameter int ADDR_W       = 40,
  parameter int LSB_W        = 6,
  parameter int SYM_W        = 7,
  parameter int HALF_BIT     = 3,
  parameter int DATA_LO_MAX  = 63,
  parameter int CHECK_LO_MAX = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              lo_present,
  input  logic              hi_present,
  input  logic [ADDR_W-1:0] phys_addr,
  input  logic [LSB_W-1:0]  valid_lsb,
  input  logic              ecc_mode,
  input  logic              corr,
  input  logic              sym_ok,
  input  logic              sym_is_data,
  input  logic [SYM_W-1:0]  sym_hibit,
  output logic              out_valid,
  output logic [1:0]        dimm_sel,
  output logic              err_nodimm,
  output logic              err_insuff,
  output logic              err_synd
);

  localparam logic [1:0] SEL_LO   = 2'b01;
  localparam logic [1:0] SEL_HI   = 2'b10;
  localparam logic [1:0] SEL_BOTH = 2'b11;

  logic       none_present, both_present, sym_in_lower, half_known;
  logic [1:0] sel_d;
  logic       nodimm_d, insuff_d, synd_d;

  assign none_present = !lo_present && !hi_present;
  assign both_present = lo_present && hi_present;
  assign half_known   = valid_lsb <= LSB_W'(HALF_BIT);
  assign sym_in_lower = sym_is_data ? (sym_hibit <= SYM_W'(DATA_LO_MAX))
                                    : (sym_hibit <= SYM_W'(CHECK_LO_MAX));

  always_comb begin
    sel_d    = 2'b00;
    nodimm_d = 1'b0;
    insuff_d = 1'b0;
    synd_d   = 1'b0;
    if (in_valid) begin
      if (none_present)
        nodimm_d = 1'b1;
      else if (!both_present)
        sel_d = SEL_LO;
      else if (!ecc_mode) begin
        if (half_known)
          sel_d = phys_addr[HALF_BIT] ? SEL_HI : SEL_LO;
        else
          insuff_d = 1'b1;
      end
      else if (!corr)
        sel_d = SEL_BOTH;
      else if (!sym_ok)
        synd_d = 1'b1;
      else
        sel_d = sym_in_lower ? SEL_LO : SEL_HI;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      dimm_sel   <= 2'b00;
      err_nodimm <= 1'b0;
      err_insuff <= 1'b0;
      err_synd   <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      dimm_sel   <= sel_d;
      err_nodimm <= nodimm_d;
      err_insuff <= insuff_d;
      err_synd   <= synd_d;
    end
  end

endmodule

// File: rtl/dimm_pair_resolver_chk.sv
module dimm_pair_resolver_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       lo_present,
  input logic       hi_present,
  input logic       ecc_mode,
  input logic       corr,
  input logic       out_valid,
  input logic [1:0] dimm_sel,
  input logic       err_nodimm,
  input logic       err_insuff,
  input logic       err_synd
);

  // R1
  nodimm_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !lo_present && !hi_present) |=> (err_nodimm && dimm_sel == 2'b00));

  // R2
  single_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (lo_present ^ hi_present)) |=> (dimm_sel == 2'b01));

  // R6
  uncorr_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lo_present && hi_present && ecc_mode && !corr) |=> (dimm_sel == 2'b11));

  // R8
  strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R8
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && dimm_sel == 2'b00 && !err_nodimm && !err_insuff && !err_synd));

  // R9
  result_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot({err_nodimm, err_insuff, err_synd, dimm_sel != 2'b00}));

endmodule

bind dimm_pair_resolver dimm_pair_resolver_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .lo_present (lo_present),
  .hi_present (hi_present),
  .ecc_mode   (ecc_mode),
  .corr       (corr),
  .out_valid  (out_valid),
  .dimm_sel   (dimm_sel),
  .err_nodimm (err_nodimm),
  .err_insuff (err_insuff),
  .err_synd   (err_synd)
);

// File: tb/tb_dimm_pair_resolver.sv
module tb_dimm_pair_resolver;

  localparam int ADDR_W = 40;
  localparam int LSB_W  = 6;
  localparam int SYM_W  = 7;
  localparam int NVEC   = 15;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              lo_present = 1'b0, hi_present = 1'b0;
  logic [ADDR_W-1:0] phys_addr = '0;
  logic [LSB_W-1:0]  valid_lsb = '0;
  logic              ecc_mode = 1'b0, corr = 1'b0, sym_ok = 1'b0, sym_is_data = 1'b0;
  logic [SYM_W-1:0]  sym_hibit = '0;
  logic              out_valid;
  logic [1:0]        dimm_sel;
  logic              err_nodimm, err_insuff, err_synd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dimm_pair_resolver dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .lo_present(lo_present), .hi_present(hi_present),
    .phys_addr(phys_addr), .valid_lsb(valid_lsb), .ecc_mode(ecc_mode),
    .corr(corr), .sym_ok(sym_ok), .sym_is_data(sym_is_data), .sym_hibit(sym_hibit),
    .out_valid(out_valid), .dimm_sel(dimm_sel),
    .err_nodimm(err_nodimm), .err_insuff(err_insuff), .err_synd(err_synd)
  );

  // Row layout: {req[3:0], lo, hi, mode, corr, ok, data, hibit[6:0], lsb[5:0], a3, exp_sel[1:0], exp_err[2:0]}
  // exp_err = {nodimm, insuff, synd}
  localparam logic [28:0] VEC [NVEC] = '{
    {4'd1, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 7'd0,  6'd0, 1'b1, 2'b00, 3'b100}, // R1 64/8
    {4'd1, 1'b0,1'b0,1'b1,1'b1,1'b1,1'b1, 7'd0,  6'd0, 1'b0, 2'b00, 3'b100}, // R1 symbol
    {4'd2, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 7'd0,  6'd9, 1'b1, 2'b01, 3'b000}, // R2 lower only, coarse addr
    {4'd2, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 7'd90, 6'd0, 1'b1, 2'b01, 3'b000}, // R2 upper only, uncorrectable
    {4'd3, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 7'd0,  6'd3, 1'b1, 2'b10, 3'b000}, // R3 lsb=3, bit3 set
    {4'd3, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 7'd0,  6'd0, 1'b0, 2'b01, 3'b000}, // R3 lsb=0, bit3 clear
    {4'd3, 1'b1,1'b1,1'b0,1'b1,1'b0,1'b1, 7'd99, 6'd3, 1'b0, 2'b01, 3'b000}, // R3 symbol fields ignored
    {4'd4, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 7'd0,  6'd4, 1'b1, 2'b00, 3'b010}, // R4 lsb=4
    {4'd5, 1'b1,1'b1,1'b1,1'b1,1'b1,1'b1, 7'd63, 6'd9, 1'b1, 2'b01, 3'b000}, // R5 data 63
    {4'd5, 1'b1,1'b1,1'b1,1'b1,1'b1,1'b1, 7'd64, 6'd0, 1'b0, 2'b10, 3'b000}, // R5 data 64
    {4'd5, 1'b1,1'b1,1'b1,1'b1,1'b1,1'b0, 7'd7,  6'd0, 1'b1, 2'b01, 3'b000}, // R5 check 7
    {4'd5, 1'b1,1'b1,1'b1,1'b1,1'b1,1'b0, 7'd8,  6'd0, 1'b0, 2'b10, 3'b000}, // R5 check 8
    {4'd5, 1'b1,1'b1,1'b1,1'b1,1'b1,1'b1, 7'd127,6'd0, 1'b0, 2'b10, 3'b000}, // R5 data 127
    {4'd6, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b1, 7'd3,  6'd9, 1'b0, 2'b11, 3'b000}, // R6 with sym_ok low
    {4'd7, 1'b1,1'b1,1'b1,1'b1,1'b0,1'b1, 7'd3,  6'd0, 1'b1, 2'b00, 3'b001}  // R7
  };

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {valid,sel,nodimm,insuff,synd} actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return {out_valid, dimm_sel, err_nodimm, err_insuff, err_synd};
  endfunction

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 reset", outs(), 6'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 idle after reset", outs(), 6'b0);

    for (int i = 0; i < NVEC; i++) begin
      lo_present  = VEC[i][24];
      hi_present  = VEC[i][23];
      ecc_mode    = VEC[i][22];
      corr        = VEC[i][21];
      sym_ok      = VEC[i][20];
      sym_is_data = VEC[i][19];
      sym_hibit   = VEC[i][18:12];
      valid_lsb   = VEC[i][11:6];
      phys_addr   = 40'hA5_5A3C_96F0 ^ (40'(i) << 12);
      phys_addr[3] = VEC[i][5];
      in_valid    = 1'b1;
      @(negedge clk);
      check($sformatf("R%0d vec%0d", VEC[i][28:25], i), outs(), {1'b1, VEC[i][4:0]});
    end

    // R8: idle cycle clears result and strobe
    in_valid = 1'b0;
    @(negedge clk);
    check("R8 idle clears", outs(), 6'b0);

    // R9: back-to-back requests, each with exactly one outcome
    lo_present = 1'b1; hi_present = 1'b1; ecc_mode = 1'b0; valid_lsb = 6'd2;
    phys_addr = 40'h0; in_valid = 1'b1;
    @(negedge clk);
    check("R9 b2b first", outs(), 6'b1_01_000);
    phys_addr = 40'h8;
    @(negedge clk);
    check("R9 b2b second", outs(), 6'b1_10_000);
    valid_lsb = 6'd39;
    @(negedge clk);
    check("R4 coarse max", outs(), 6'b1_00_010);

    // R8: reset mid-stream clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 reset mid-stream", outs(), 6'b0);
    rst_n = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    check("R8 idle after reset", outs(), 6'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule